// File: doc/BRIEF.md
# Nibble-Loaded Pattern Bank Mapper

This block keeps eight 1 KB pattern-table bank numbers and turns a video-side pattern address into a character-ROM address. The processor loads each bank number in two halves. A write whose address decodes into the character-bank window carries four useful data bits. The write address picks which of the eight banks is written and whether the lower or the upper half of that bank number is replaced.

On the video side, addresses below 0x2000 are pattern fetches. Bits [12:10] pick one of the eight banks. The chosen bank number is limited by a size mask and placed above the 10-bit offset within the page. Addresses at 0x2000 and above are not served by this block: the hit flag drops and the ROM address reads zero.

Top module: `chr_nibble_bank`

## Requirements
- R1: After a synchronous active-high reset, all eight bank numbers read as zero.
- R2: A strobed write updates a bank only when (cpu_addr & 0xF80C) is at least 0xB000 and at most 0xE00C. All other addresses leave every bank unchanged.
- R3: The target bank is ((((cpu_addr >> 11) - 6) | (cpu_addr >> 3)) & 7). For example, 0xB000→0, 0xB008→1, 0xB010→2, 0xC000→2, 0xD008→5, 0xE008→7. Exactly one bank can change per write.
- R4: When cpu_addr bit 2 is 0, cpu_data[3:0] replaces bits [3:0] of the target bank, and bits [7:4] are kept.
- R5: When cpu_addr bit 2 is 1, cpu_data[3:0] replaces bits [7:4] of the target bank, and bits [3:0] are kept.
- R6: cpu_data[7:4] has no effect on any bank.
- R7: When cpu_we is low, no bank changes.
- R8: When ppu_addr < 0x2000, chr_hit is 1 and chr_addr = {bank[ppu_addr[12:10]] & chr_mask, ppu_addr[9:0]}. The result is combinational in the same cycle.
- R9: When ppu_addr >= 0x2000, chr_hit is 0 and chr_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_we | input | 1 | Processor write strobe, one write per cycle |
| cpu_addr | input | 16 | Processor write address |
| cpu_data | input | 8 | Processor write data (low four bits used) |
| ppu_addr | input | 14 | Video pattern/nametable address |
| chr_mask | input | 8 | Bank size mask (ROM size in 1 KB pages minus one) |
| chr_addr | output | 18 | Character ROM byte address |
| chr_hit | output | 1 | High when ppu_addr falls in the pattern area |

## Verification
On every cycle the assertions check several properties. The banks hold when no strobe is present or the address misses the window. At most one bank changes per write. The untouched half of a bank survives a write to either half. The output follows the pattern/nametable split in both the hit flag and the page offset. What the assertions cannot show is the exact index each scattered address reaches, the value of the nibble written, and the effect of the size mask. The bench's scenarios show these by reading every bank back through the video port after each write.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
    localparam int NUM_BANKS = 8;
    localparam int IDX_W     = $clog2(NUM_BANKS);
    localparam int NIB_W     = 4;
    localparam int BANK_W    = 2 * NIB_W;
    localparam int CPU_AW    = 16;
    localparam int PAGE_AW   = 10;

    localparam logic [CPU_AW-1:0] WIN_MASK = 16'hF80C;
    localparam logic [CPU_AW-1:0] WIN_LO   = 16'hB000;
    localparam logic [CPU_AW-1:0] WIN_HI   = 16'hE00C;

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_arr_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             upper;
    } wr_cmd_t;

    typedef struct packed {
        bank_arr_t bank;
    } bank_state_t;
endpackage

// File: rtl/chr_bank_decode.sv
module chr_bank_decode
    import chr_bank_pkg::*;
(
    input  logic              we,
    input  logic [CPU_AW-1:0] addr,
    output wr_cmd_t           cmd
);
    logic [CPU_AW-1:0] masked;
    logic [4:0]        page_hi;
    logic [4:0]        page_off;

    always_comb begin
        masked   = addr & WIN_MASK;
        page_hi  = addr[15:11];
        page_off = page_hi - 5'd6;
        cmd.hit   = we && (masked >= WIN_LO) && (masked <= WIN_HI);
        cmd.idx   = page_off[IDX_W-1:0] | addr[IDX_W+2:3];
        cmd.upper = addr[2];
    end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic [NIB_W-1:0] nib,
    output bank_arr_t        banks_q
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.hit) begin
            if (cmd.upper)
                st_d.bank[cmd.idx][BANK_W-1:NIB_W] = nib;
            else
                st_d.bank[cmd.idx][NIB_W-1:0] = nib;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign banks_q = st_q.bank;
endmodule

// File: rtl/chr_bank_map.sv
module chr_bank_map
    import chr_bank_pkg::*;
#(
    parameter int PPU_AW = 14
) (
    input  bank_arr_t                   banks,
    input  logic [PPU_AW-1:0]           ppu_addr,
    input  logic [BANK_W-1:0]           mask,
    output logic [BANK_W+PAGE_AW-1:0]   rom_addr,
    output logic                        hit
);
    localparam int SEL_LSB = PAGE_AW;

    logic [IDX_W-1:0]  sel;
    logic [BANK_W-1:0] page;

    always_comb begin
        sel  = ppu_addr[SEL_LSB+IDX_W-1:SEL_LSB];
        hit  = (ppu_addr[PPU_AW-1:SEL_LSB+IDX_W] == '0);
        page = banks[sel] & mask;
        rom_addr = hit ? {page, ppu_addr[PAGE_AW-1:0]} : '0;
    end
endmodule

// File: rtl/chr_nibble_bank.sv
module chr_nibble_bank
    import chr_bank_pkg::*;
#(
    parameter int PPU_AW = 14
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cpu_we,
    input  logic [CPU_AW-1:0]           cpu_addr,
    input  logic [BANK_W-1:0]           cpu_data,
    input  logic [PPU_AW-1:0]           ppu_addr,
    input  logic [BANK_W-1:0]           chr_mask,
    output logic [BANK_W+PAGE_AW-1:0]   chr_addr,
    output logic                        chr_hit
);
    wr_cmd_t   cmd;
    bank_arr_t banks_q;

    chr_bank_decode u_dec (
        .we   (cpu_we),
        .addr (cpu_addr),
        .cmd  (cmd)
    );

    chr_bank_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .nib     (cpu_data[NIB_W-1:0]),
        .banks_q (banks_q)
    );

    chr_bank_map #(.PPU_AW(PPU_AW)) u_map (
        .banks    (banks_q),
        .ppu_addr (ppu_addr),
        .mask     (chr_mask),
        .rom_addr (chr_addr),
        .hit      (chr_hit)
    );
endmodule

// File: rtl/chr_nibble_bank_chk.sv
module chr_nibble_bank_chk
    import chr_bank_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      cpu_we,
    input logic [CPU_AW-1:0]         cpu_addr,
    input logic                      dec_hit,
    input bank_arr_t                 banks,
    input logic [13:0]               ppu_addr,
    input logic [BANK_W+PAGE_AW-1:0] chr_addr,
    input logic                      chr_hit
);
    bank_arr_t            prev;
    logic                 prev_ok;
    logic [NUM_BANKS-1:0] changed;
    logic [NUM_BANKS-1:0] hi_moved;
    logic [NUM_BANKS-1:0] lo_moved;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else begin
            prev    <= banks;
            prev_ok <= 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            changed[i]  = banks[i] != prev[i];
            hi_moved[i] = banks[i][BANK_W-1:NIB_W] != prev[i][BANK_W-1:NIB_W];
            lo_moved[i] = banks[i][NIB_W-1:0] != prev[i][NIB_W-1:0];
        end
    end

    assert_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !cpu_we |=> $stable(banks));

    assert_outside_window_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !dec_hit) |=> $stable(banks));

    assert_single_bank_R3: assert property (@(posedge clk) disable iff (rst)
        prev_ok |-> $onehot0(changed));

    assert_keep_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !cpu_addr[2]) |=> (hi_moved == '0));

    assert_keep_lower_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[2]) |=> (lo_moved == '0));

    assert_pattern_offset_R8: assert property (@(posedge clk) disable iff (rst)
        (ppu_addr[13] == 1'b0) |-> (chr_hit && chr_addr[PAGE_AW-1:0] == ppu_addr[PAGE_AW-1:0]));

    assert_nametable_miss_R9: assert property (@(posedge clk) disable iff (rst)
        ppu_addr[13] |-> (!chr_hit && chr_addr == '0));
endmodule

bind chr_nibble_bank chr_nibble_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .dec_hit  (cmd.hit),
    .banks    (banks_q),
    .ppu_addr (ppu_addr),
    .chr_addr (chr_addr),
    .chr_hit  (chr_hit)
);

// File: tb/chr_nibble_bank_tb.sv
module chr_nibble_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [7:0]  chr_mask = 8'hFF;
    logic [17:0] chr_addr;
    logic        chr_hit;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    chr_nibble_bank dut_i (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .chr_mask(chr_mask),
        .chr_addr(chr_addr), .chr_hit(chr_hit)
    );

    function automatic int idx_of(input int a);
        return (((a >> 11) - 6) | (a >> 3)) & 7;
    endfunction

    function automatic bit in_win(input int a);
        int m;
        m = a & 'hF80C;
        return (m >= 'hB000) && (m <= 'hE00C);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_we = strobe; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_we = 1'b0;
        if (strobe && in_win(int'(a))) begin
            if (a[2]) model[idx_of(int'(a))][7:4] = d[3:0];
            else      model[idx_of(int'(a))][3:0] = d[3:0];
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 8; i++) begin
            ppu_addr = {1'b0, 3'(i), 10'h155};
            #1;
            check(req, {14'd0, chr_hit, chr_addr}, {14'd0, 1'b1, model[i] & chr_mask, 10'h155});
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        read_all("R1");
    endtask

    task automatic t_all_indices;
        logic [15:0] bases [8];
        bases = '{16'hB000, 16'hB008, 16'hC000, 16'hC008,
                  16'hD000, 16'hD008, 16'hE000, 16'hE008};
        for (int i = 0; i < 8; i++) begin
            wr(bases[i], 8'(i + 1), 1'b1);
            read_all("R4");
            wr(bases[i] | 16'h0004, 8'(8 - i), 1'b1);
            read_all("R5");
            check("R3", {24'd0, model[i]}, {24'd0, 4'(8 - i), 4'(i + 1)});
        end
    endtask

    task automatic t_scattered_index;
        wr(16'hB010, 8'h0A, 1'b1);
        check("R3", {29'd0, 3'(idx_of('hB010))}, 32'd2);
        read_all("R3");
        wr(16'hC024, 8'h0C, 1'b1);
        read_all("R3");
    endtask

    task automatic t_outside;
        logic [15:0] miss [6];
        miss = '{16'hA80C, 16'hAFFC, 16'hE80C, 16'hF000, 16'h8000, 16'h9804};
        for (int i = 0; i < 6; i++) begin
            wr(miss[i], 8'h0F, 1'b1);
            read_all("R2");
        end
    endtask

    task automatic t_no_strobe;
        wr(16'hB000, 8'h07, 1'b0);
        wr(16'hE00C, 8'h03, 1'b0);
        read_all("R7");
    endtask

    task automatic t_upper_data;
        wr(16'hD000, 8'hF0, 1'b1);
        read_all("R6");
        check("R6", {28'd0, model[4][3:0]}, 32'd0);
    endtask

    task automatic t_mask;
        chr_mask = 8'h0F;
        read_all("R8");
        chr_mask = 8'h30;
        read_all("R8");
        chr_mask = 8'hFF;
    endtask

    task automatic t_nametable;
        logic [13:0] na [3];
        na = '{14'h2000, 14'h2C55, 14'h3FFF};
        for (int i = 0; i < 3; i++) begin
            ppu_addr = na[i];
            #1;
            check("R9", {13'd0, chr_hit, chr_addr}, 32'd0);
        end
        ppu_addr = 14'h1FFF;
        #1;
        check("R8", {13'd0, chr_hit, chr_addr}, {13'd0, 1'b1, model[7], 10'h3FF});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_all_indices();
        t_scattered_index();
        t_outside();
        t_no_strobe();
        t_upper_data();
        t_mask();
        t_nametable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule